// File: doc/BRIEF.md
# H-Bridge Gate-Drive Fault Sequencer

This block decides, every clock cycle, what state the outputs of a gate driver with two bridge pairs should be in, and when the active-low shutdown line to the upstream PWM controller should be asserted. Any error event on its inputs sets a shared fault latch. After a programmed delay the latch pulls `shutdown_n` low. Each running bridge pair then leaves normal operation. The exit mode depends on the static `hiz_sel` pin: with `hiz_sel` low the pair goes to all-low, and with `hiz_sel` high it goes to high impedance, which suits bridge-tied loads.

The controller answers a fault by lowering a pair's reset input. That falling edge grounds the pair's outputs so the bootstrap capacitors can recharge. If the error has gone, it also clears the latch, which releases `shutdown_n`. When the reset input rises again with the latch clear, the pair returns to normal operation after a further delay.

At power-up the latch is set and every output is all-low, so a reset toggle is needed before the first use. All inputs pass through synchronisers. Every delay is a parameter counted in clock cycles. Each delay is measured from the cycle in which its cause changes at the pins, and the synchroniser and edge detection add a fixed `SYNC_STAGES + 2` cycles to it.

Top module: `hb_fault_seq`

## Requirements
- R1: After `rst_n` is released, every pair reports code 00 (all-low) and `shutdown_n` is 0. This holds until a pair reset input has been taken low and back high.
- R2: When an error line goes high, `shutdown_n` goes low D_ERR_SD + SYNC_STAGES + 2 cycles later. It stays low after the error line drops, for as long as all pair resets stay high.
- R3: With `hiz_sel` = 0, a pair in normal operation reports 00 (all-low) D_ERR_OUT + SYNC_STAGES + 2 cycles after an error line goes high.
- R4: With `hiz_sel` = 1, a pair in normal operation reports 10 (high-Z) in the same cycle that `shutdown_n` falls. High-Z is never reported while `hiz_sel` = 0.
- R5: A falling edge on `pair_rst_n[p]` makes pair p report 00 D_RST_LOW + SYNC_STAGES + 2 cycles later.
- R6: If no error line is active, a falling edge on any pair reset clears the fault latch. `shutdown_n` then returns to 1 D_RST_SD + SYNC_STAGES + 2 cycles after that edge.
- R7: A rising edge on `pair_rst_n[p]` with the latch clear makes pair p report 01 (normal) D_RST_OP + SYNC_STAGES + 2 cycles later.
- R8: If an error is present while the pair resets are low, the latch is set and stays set. The next rising reset edge leaves the pairs at 00, and `shutdown_n` stays 0.
- R9: Pairs are independent: a reset edge on one pair does not change another pair's code. Bit p of `pair_rst_n` belongs to pair p, and pair p's code is `pair_state[2p+1:2p]`.
- R10: Code 11 never appears on any pair.
- R11: Each bit of `err_evt` alone is enough to raise a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| err_evt | input | NUM_ERR | Error event lines, active high, asynchronous |
| pair_rst_n | input | NUM_PAIRS | Active-low reset per bridge pair, asynchronous |
| hiz_sel | input | 1 | Static fault mode: 1 high-Z, 0 all-low |
| pair_state | output | 2*NUM_PAIRS | Per-pair output code: 00 all-low, 01 normal, 10 high-Z |
| shutdown_n | output | 1 | Active-low shutdown request to the PWM controller |

## Verification
Every delay is measured as an exact cycle count from the input change to the output change. A count that is one cycle off in the synchroniser, the edge detector or a down-counter is therefore visible, and is not hidden by a loose window. The fault episode is swept over each error line and both fault modes. This separates the all-low exit, which has its own counter, from the high-Z exit, which is tied to the fall of `shutdown_n`. Single-pair reset toggles show whether the pairs are independent. An error injected while the resets are low shows whether the latch is kept across a rising edge or wrongly cleared by it.

// File: rtl/hbf_pkg.sv
`timescale 1ns/1ps
package hbf_pkg;

   typedef enum logic [1:0] {
      OUT_LOW = 2'b00,
      OUT_RUN = 2'b01,
      OUT_HIZ = 2'b10
   } out_code_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_TO_LOW,
      PH_TO_RUN,
      PH_TO_FLT
   } phase_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      return max2(max2(a, b), c);
   endfunction

   // counter width able to hold any delay up to m
   function automatic int cnt_w(input int m);
      return $clog2(m + 2);
   endfunction

endpackage

// File: rtl/hbf_sync.sv
`timescale 1ns/1ps
module hbf_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbf_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("hbf_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/hbf_follow.sv
`timescale 1ns/1ps
// Delayed follower: q takes the value of tgt once tgt has differed from q
// for a number of cycles that depends on the direction of the change.
module hbf_follow #(
   parameter int   D_FALL = 3,
   parameter int   D_RISE = 4,
   parameter logic RST_Q  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgt,
   output logic q,
   output logic fall_now
);

   localparam int CW = hbf_pkg::cnt_w(hbf_pkg::max2(D_FALL, D_RISE));
   localparam logic [CW-1:0] LIM_F = CW'(D_FALL);
   localparam logic [CW-1:0] LIM_R = CW'(D_RISE);

   generate
      if (D_FALL < 0 || D_RISE < 0) begin : g_bad_delay
         $error("hbf_follow: delays must not be negative");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim      = tgt ? LIM_R : LIM_F;
   assign fall_now = q & ~tgt & (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= RST_Q;
         cnt <= '0;
      end else if (tgt == q) begin
         cnt <= '0;
      end else if (cnt == lim) begin
         q   <= tgt;
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_FOLLOW_TOWARD_TGT: assert property (@(posedge clk) disable iff (!rst_n)
      (q != $past(q)) |-> (q == $past(tgt)));  // R2

   AST_NO_EARLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (q != $past(q)) |-> ($past(tgt) != $past(q)));  // R6

endmodule

// File: rtl/hbf_pair.sv
`timescale 1ns/1ps
module hbf_pair #(
   parameter int D_ERR_OUT = 5,
   parameter int D_RST_LOW = 2,
   parameter int D_RST_OP  = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rst_lvl,
   input  logic       rst_fall,
   input  logic       rst_rise,
   input  logic       err_lat,
   input  logic       err_new,
   input  logic       sd_fall,
   input  logic       hiz_sel,
   output logic [1:0] code_o
);
   import hbf_pkg::*;

   localparam int CW = cnt_w(max3(D_ERR_OUT, D_RST_LOW, D_RST_OP));
   localparam logic [CW-1:0] LIM_FLT = CW'(D_ERR_OUT);
   localparam logic [CW-1:0] LIM_LOW = CW'(D_RST_LOW);
   localparam logic [CW-1:0] LIM_OP  = CW'(D_RST_OP);

   generate
      if (D_ERR_OUT < 0 || D_RST_LOW < 0 || D_RST_OP < 0) begin : g_bad_delay
         $error("hbf_pair: delays must not be negative");
      end
   endgenerate

   phase_e        phase;
   out_code_e     out_q;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         out_q <= OUT_LOW;
         cnt   <= '0;
      end else if (rst_fall) begin
         phase <= PH_TO_LOW;
         cnt   <= LIM_LOW;
      end else if (rst_rise) begin
         out_q <= OUT_LOW;
         if (!err_lat && !err_new) begin
            phase <= PH_TO_RUN;
            cnt   <= LIM_OP;
         end else begin
            phase <= PH_IDLE;
         end
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (err_new && out_q == OUT_RUN && !hiz_sel) begin
                  phase <= PH_TO_FLT;
                  cnt   <= LIM_FLT;
               end else if (sd_fall && hiz_sel && out_q == OUT_RUN) begin
                  out_q <= OUT_HIZ;
               end
            end
            PH_TO_FLT, PH_TO_LOW: begin
               if (cnt == '0) begin
                  out_q <= OUT_LOW;
                  phase <= PH_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_TO_RUN: begin
               if (err_lat || err_new) begin
                  phase <= PH_IDLE;
               end else if (cnt == '0) begin
                  out_q <= OUT_RUN;
                  phase <= PH_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign code_o = out_q;

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      code_o != 2'b11);  // R10

   AST_RUN_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q == OUT_RUN && $past(out_q) != OUT_RUN) |-> !$past(err_lat));  // R8

   AST_RUN_NEEDS_RESET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q == OUT_RUN && $past(out_q) != OUT_RUN) |-> $past(rst_lvl));  // R7

   AST_HIZ_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q == OUT_HIZ) |-> hiz_sel);  // R4

endmodule

// File: rtl/hb_fault_seq.sv
`timescale 1ns/1ps
module hb_fault_seq #(
   parameter int NUM_ERR     = 2,
   parameter int NUM_PAIRS   = 2,
   parameter int SYNC_STAGES = 2,
   parameter int D_ERR_SD    = 3,
   parameter int D_ERR_OUT   = 5,
   parameter int D_RST_LOW   = 2,
   parameter int D_RST_SD    = 4,
   parameter int D_RST_OP    = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_ERR-1:0]     err_evt,
   input  logic [NUM_PAIRS-1:0]   pair_rst_n,
   input  logic                   hiz_sel,
   output logic [2*NUM_PAIRS-1:0] pair_state,
   output logic                   shutdown_n
);

   generate
      if (NUM_ERR < 1) begin : g_bad_err
         $error("hb_fault_seq: NUM_ERR must be at least 1");
      end
      if (NUM_PAIRS < 1) begin : g_bad_pairs
         $error("hb_fault_seq: NUM_PAIRS must be at least 1");
      end
   endgenerate

   logic [NUM_ERR-1:0]   err_s_v;
   logic [NUM_PAIRS-1:0] rst_s;
   logic [NUM_PAIRS-1:0] rst_q;
   logic [NUM_PAIRS-1:0] rst_fall;
   logic [NUM_PAIRS-1:0] rst_rise;
   logic                 err_s;
   logic                 err_lat;
   logic                 err_new;
   logic                 sd_fall;

   hbf_sync #(.W(NUM_ERR), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_err_sync (
      .clk(clk), .rst_n(rst_n), .d(err_evt), .q(err_s_v));

   hbf_sync #(.W(NUM_PAIRS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_rst_sync (
      .clk(clk), .rst_n(rst_n), .d(pair_rst_n), .q(rst_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= '1;
      else        rst_q <= rst_s;
   end

   assign rst_fall = rst_q & ~rst_s;
   assign rst_rise = ~rst_q & rst_s;
   assign err_s    = |err_s_v;
   assign err_new  = err_s & ~err_lat;

   // shared fault latch: set by any error, cleared while any pair reset is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          err_lat <= 1'b1;
      else if (err_s)      err_lat <= 1'b1;
      else if (~&rst_s)    err_lat <= 1'b0;
   end

   hbf_follow #(.D_FALL(D_ERR_SD), .D_RISE(D_RST_SD), .RST_Q(1'b0)) u_sd (
      .clk(clk), .rst_n(rst_n), .tgt(~err_lat), .q(shutdown_n), .fall_now(sd_fall));

   generate
      for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
         hbf_pair #(.D_ERR_OUT(D_ERR_OUT), .D_RST_LOW(D_RST_LOW), .D_RST_OP(D_RST_OP)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .rst_lvl  (rst_s[p]),
            .rst_fall (rst_fall[p]),
            .rst_rise (rst_rise[p]),
            .err_lat  (err_lat),
            .err_new  (err_new),
            .sd_fall  (sd_fall),
            .hiz_sel  (hiz_sel),
            .code_o   (pair_state[2*p +: 2]));
      end
   endgenerate

   AST_LATCH_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      err_s |=> err_lat);  // R11

   AST_SD_FALL_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shutdown_n) |-> $past(err_lat));  // R2

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (err_lat && &rst_s) |=> err_lat);  // R8

endmodule

// File: tb/hb_fault_seq_tb.sv
`timescale 1ns/1ps
module hb_fault_seq_tb_top;

   localparam int NE  = 2;
   localparam int NP  = 2;
   localparam int SS  = 2;
   localparam int DES = 3;
   localparam int DEO = 5;
   localparam int DRL = 2;
   localparam int DRS = 4;
   localparam int DRO = 6;
   localparam int L   = SS + 2;

   localparam logic [1:0] C_LOW = 2'b00;
   localparam logic [1:0] C_RUN = 2'b01;
   localparam logic [1:0] C_HIZ = 2'b10;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NE-1:0] err_evt;
   logic [NP-1:0] prn;
   logic          hiz_sel;
   logic [2*NP-1:0] pst;
   logic          sd_n;

   int checks   = 0;
   int errors   = 0;
   int bad_code = 0;

   always #5 clk = ~clk;

   hb_fault_seq #(
      .NUM_ERR(NE), .NUM_PAIRS(NP), .SYNC_STAGES(SS), .D_ERR_SD(DES),
      .D_ERR_OUT(DEO), .D_RST_LOW(DRL), .D_RST_SD(DRS), .D_RST_OP(DRO)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .pair_rst_n(prn),
      .hiz_sel(hiz_sel), .pair_state(pst), .shutdown_n(sd_n));

   function automatic logic [1:0] st(input int p);
      return pst[2*p +: 2];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // count negedges until pair p shows code and shutdown_n shows sdv
   task automatic watch(input int p, input logic [1:0] code, input logic sdv,
                        output int ts, output int tsd);
      ts  = 0;
      tsd = 0;
      for (int n = 1; n <= 100; n++) begin
         @(negedge clk);
         if (ts == 0 && st(p) == code) ts = n;
         if (tsd == 0 && sd_n == sdv) tsd = n;
         if (ts != 0 && tsd != 0) break;
      end
   endtask

   // R10: watch every cycle for the unused code
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         for (int p = 0; p < NP; p++) if (st(p) == 2'b11) bad_code++;
      end
   end

   task automatic do_reset(input logic m);
      @(negedge clk);
      rst_n   = 1'b0;
      prn     = '1;
      err_evt = '0;
      hiz_sel = m;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic bring_up();
      int ts, tsd;
      logic was_low;
      was_low = (st(0) == C_LOW);
      prn = '0;
      watch(0, C_LOW, 1'b1, ts, tsd);
      chk(tsd == DRS + L, "R6 shutdown release latency", tsd, DRS + L);
      if (!was_low) chk(ts == DRL + L, "R5 reset-to-low latency", ts, DRL + L);
      cyc(12);
      prn = '1;
      watch(0, C_RUN, 1'b1, ts, tsd);
      chk(ts == DRO + L, "R7 reset-to-run latency", ts, DRO + L);
      chk(st(1) == C_RUN, "R7 second pair running", st(1), C_RUN);
   endtask

   initial begin
      int ts, tsd;
      rst_n   = 1'b0;
      prn     = '1;
      err_evt = '0;
      hiz_sel = 1'b0;
      do_reset(1'b0);

      chk(st(0) == C_LOW, "R1 pair0 after reset", st(0), C_LOW);
      chk(st(1) == C_LOW, "R1 pair1 after reset", st(1), C_LOW);
      chk(sd_n == 1'b0, "R1 shutdown after reset", sd_n, 0);
      cyc(20);
      chk(st(0) == C_LOW && st(1) == C_LOW, "R1 held without toggle", pst, 0);
      chk(sd_n == 1'b0, "R1 shutdown held", sd_n, 0);

      for (int m = 0; m < 2; m++) begin
         do_reset(m[0]);
         bring_up();
         for (int e = 0; e < NE; e++) begin
            err_evt[e] = 1'b1;
            if (m == 0) begin
               watch(0, C_LOW, 1'b0, ts, tsd);
               chk(ts == DEO + L, "R3 R11 error-to-low latency", ts, DEO + L);
               chk(st(1) == C_LOW, "R3 second pair low", st(1), C_LOW);
            end else begin
               watch(0, C_HIZ, 1'b0, ts, tsd);
               chk(ts == DES + L, "R4 R11 hi-Z with shutdown fall", ts, DES + L);
               chk(st(1) == C_HIZ, "R4 second pair hi-Z", st(1), C_HIZ);
            end
            chk(tsd == DES + L, "R2 error-to-shutdown latency", tsd, DES + L);
            cyc(10);
            err_evt = '0;
            cyc(10);
            chk(sd_n == 1'b0, "R2 latch holds shutdown", sd_n, 0);
            chk(st(0) == (m == 0 ? C_LOW : C_HIZ), "R2 latched pair code", st(0),
                (m == 0 ? C_LOW : C_HIZ));
            bring_up();
         end
      end

      // R9: single-pair reset toggles (hi-Z mode, no error)
      for (int p = 0; p < NP; p++) begin
         prn[p] = 1'b0;
         watch(p, C_LOW, 1'b1, ts, tsd);
         chk(ts == DRL + L, "R5 single pair reset-to-low", ts, DRL + L);
         cyc(10);
         chk(st(1 - p) == C_RUN, "R9 other pair untouched", st(1 - p), C_RUN);
         chk(sd_n == 1'b1, "R9 shutdown stays high", sd_n, 1);
         prn[p] = 1'b1;
         watch(p, C_RUN, 1'b1, ts, tsd);
         chk(ts == DRO + L, "R7 single pair back to run", ts, DRO + L);
         chk(st(1 - p) == C_RUN, "R9 other pair still running", st(1 - p), C_RUN);
      end

      // R8: error present while resets are low
      prn = '0;
      cyc(30);
      err_evt[0] = 1'b1;
      cyc(15);
      chk(sd_n == 1'b0, "R8 shutdown low on error during reset", sd_n, 0);
      prn = '1;
      cyc(DRO + L + 10);
      chk(st(0) == C_LOW, "R8 pair0 stays low", st(0), C_LOW);
      chk(st(1) == C_LOW, "R8 pair1 stays low", st(1), C_LOW);
      chk(sd_n == 1'b0, "R8 shutdown stays low", sd_n, 0);
      err_evt = '0;
      cyc(15);
      chk(st(0) == C_LOW && sd_n == 1'b0, "R8 latch kept after error ends", st(0), C_LOW);
      bring_up();

      chk(bad_code == 0, "R10 unused code seen", bad_code, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule